// File: doc/BRIEF.md
# Parallel Sample Record Framer

This block sits on a per-channel sample bus. Each bus word holds several two's-complement samples side by side in lanes of equal width, with the most significant bit of each converter value at the top bit of its lane. A single valid bit qualifies the whole word. A 16-bit sideband travels with the word. The block registers the stream once. It cuts the valid words into records of a programmable length and marks the first and last word of each record with inclusive start and stop strobes.

For each valid word the block raises an overrange flag when any lane sits at either end of full scale. It keeps the sideband of the word that opened the current record as a header word. It also watches a second, incoming pair of start/stop strobes for framing violations and reports them through a sticky error flag.

All data outputs lag the inputs by exactly one clock. Words with valid low are not counted and are not forwarded.

Top module: `recordFramer`

## Requirements
- R1: While reset is held, and in the first cycle after it, outValid, outStart, outStop, outOverrange and protoErr are 0, and outData, outGp and outHeader are all zeros.
- R2: outValid equals inValid of the previous cycle. outData takes inData one cycle after a valid word and otherwise holds its value.
- R3: outOverrange is 1 one cycle after a valid word in which any lane equals the most negative value (MSB only set) or the most positive value (all bits below the MSB set). It is 0 otherwise. Lane i occupies inData bits [i*BITS +: BITS].
- R4: Counting from reset, the valid words form back-to-back records of exactly max(recLen,2) words. outStart marks the first word of each record and outStop marks the last.
- R5: A recLen of 0 or 1 produces records of two valid words.
- R6: outStart and outStop are never high together. Neither strobe, nor outOverrange, is high without outValid.
- R7: Cycles with inValid low do not advance the record position. Their inStart, inStop and inData have no effect.
- R8: outHeader takes the inGp value of a record's first word in the same cycle that outStart is shown. It holds that value until the next record starts.
- R9: outGp takes inGp only from valid words. It holds its value across invalid cycles.
- R10: In a valid cycle, protoErr becomes 1 on the next cycle in three cases: inStart arrives while an incoming record is open, inStop arrives while none is open, or inStart and inStop arrive together. Once set, protoErr stays 1 until cleared.
- R11: errClear high makes protoErr 0 on the next cycle. It takes priority over an error detected in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| recLen | input | LEN_W | Programmed record length in valid words |
| inValid | input | 1 | Qualifies all lanes of inData |
| inData | input | LANES*BITS | Parallel two's-complement samples |
| inGp | input | 16 | General-purpose sideband |
| inStart | input | 1 | Incoming record-start strobe (checked only) |
| inStop | input | 1 | Incoming record-stop strobe (checked only) |
| errClear | input | 1 | Synchronous clear of protoErr |
| outValid | output | 1 | Registered valid |
| outData | output | LANES*BITS | Registered samples |
| outOverrange | output | 1 | Some lane of the word is at full scale |
| outStart | output | 1 | First word of a generated record |
| outStop | output | 1 | Last word of a generated record |
| outGp | output | 16 | Sideband from the latest valid word |
| outHeader | output | 16 | Sideband captured at record start |
| protoErr | output | 1 | Sticky incoming-framing error |

## Verification
The overrange detector is driven with every pair of lane values in a two-lane, four-bit configuration. This separates a hit in lane 0 from a hit in lane 1, the positive extreme from the negative one, and the values just inside full scale from the extremes. The same sweep runs with invalid words inserted at a fixed interval. Those invalid words show whether record counting, held data and the sideband freeze on gaps. Records are checked at length three and with the clamped lengths zero and one. A scripted sequence of incoming strobes covers each error cause, strobes that arrive in invalid cycles, and a clear that coincides with a new error.

// File: rtl/recordFramerPkg.sv
package recordFramerPkg;
  typedef struct packed {
    logic fire;
    logic recStart;
    logic recStop;
  } frameCtl_t;
endpackage

// File: rtl/recordFramerCtrl.sv
module recordFramerCtrl
  import recordFramerPkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] recLen,
  input  logic             inValid,
  input  logic             inStart,
  input  logic             inStop,
  input  logic             errClear,
  output frameCtl_t        ctl,
  output logic             protoErr
);
  localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(2);

  logic [LEN_W-1:0] wordPos;
  logic [LEN_W-1:0] lenEff;
  logic [LEN_W-1:0] lastIdx;
  logic             atLast;
  logic             rxOpen;
  logic             rxErr;

  // Clamp the programmed length: start and stop may not share a word.
  always_comb begin
    lenEff  = (recLen < MIN_LEN) ? MIN_LEN : recLen;
    lastIdx = lenEff - LEN_W'(1);
    atLast  = (wordPos >= lastIdx);
  end

  always_comb begin
    ctl.fire     = inValid;
    ctl.recStart = inValid && (wordPos == '0);
    ctl.recStop  = inValid && atLast;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wordPos <= '0;
    end else if (inValid) begin
      wordPos <= atLast ? '0 : wordPos + LEN_W'(1);
    end
  end

  // Checker for the incoming framing strobes.
  always_comb begin
    rxErr = inValid && ((inStart && inStop) ||
                        (inStart && rxOpen) ||
                        (inStop && !rxOpen));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxOpen   <= 1'b0;
      protoErr <= 1'b0;
    end else begin
      if (inValid && inStart && !inStop) rxOpen <= 1'b1;
      else if (inValid && inStop && !inStart) rxOpen <= 1'b0;
      if (errClear) protoErr <= 1'b0;
      else if (rxErr) protoErr <= 1'b1;
    end
  end
endmodule

// File: rtl/recordFramerPath.sv
module recordFramerPath
  import recordFramerPkg::*;
#(
  parameter int LANES = 4,
  parameter int BITS  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  frameCtl_t             ctl,
  input  logic [LANES*BITS-1:0] inData,
  input  logic [15:0]           inGp,
  output logic                  outValid,
  output logic [LANES*BITS-1:0] outData,
  output logic                  outOverrange,
  output logic                  outStart,
  output logic                  outStop,
  output logic [15:0]           outGp,
  output logic [15:0]           outHeader
);
  localparam logic [BITS-1:0] NEG_FS = {1'b1, {(BITS-1){1'b0}}};
  localparam logic [BITS-1:0] POS_FS = {1'b0, {(BITS-1){1'b1}}};

  logic [LANES-1:0] laneHit;
  logic             anyHit;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : gLane
      logic [BITS-1:0] laneVal;
      assign laneVal    = inData[g*BITS +: BITS];
      assign laneHit[g] = (laneVal == NEG_FS) || (laneVal == POS_FS);
    end
  endgenerate

  assign anyHit = |laneHit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid     <= 1'b0;
      outData      <= '0;
      outOverrange <= 1'b0;
      outStart     <= 1'b0;
      outStop      <= 1'b0;
      outGp        <= '0;
      outHeader    <= '0;
    end else begin
      outValid     <= ctl.fire;
      outOverrange <= ctl.fire && anyHit;
      outStart     <= ctl.recStart;
      outStop      <= ctl.recStop;
      if (ctl.fire) begin
        outData <= inData;
        outGp   <= inGp;
      end
      if (ctl.recStart) outHeader <= inGp;
    end
  end
endmodule

// File: rtl/recordFramer.sv
module recordFramer
  import recordFramerPkg::*;
#(
  parameter int LANES = 4,
  parameter int BITS  = 16,
  parameter int LEN_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LEN_W-1:0]      recLen,
  input  logic                  inValid,
  input  logic [LANES*BITS-1:0] inData,
  input  logic [15:0]           inGp,
  input  logic                  inStart,
  input  logic                  inStop,
  input  logic                  errClear,
  output logic                  outValid,
  output logic [LANES*BITS-1:0] outData,
  output logic                  outOverrange,
  output logic                  outStart,
  output logic                  outStop,
  output logic [15:0]           outGp,
  output logic [15:0]           outHeader,
  output logic                  protoErr
);
  frameCtl_t ctl;

  recordFramerCtrl #(.LEN_W(LEN_W)) uCtrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .recLen   (recLen),
    .inValid  (inValid),
    .inStart  (inStart),
    .inStop   (inStop),
    .errClear (errClear),
    .ctl      (ctl),
    .protoErr (protoErr)
  );

  recordFramerPath #(.LANES(LANES), .BITS(BITS)) uPath (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl          (ctl),
    .inData       (inData),
    .inGp         (inGp),
    .outValid     (outValid),
    .outData      (outData),
    .outOverrange (outOverrange),
    .outStart     (outStart),
    .outStop      (outStop),
    .outGp        (outGp),
    .outHeader    (outHeader)
  );
endmodule

// File: rtl/recordFramerChk.sv
module recordFramerChk #(
  parameter int LANES = 4,
  parameter int BITS  = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  inValid,
  input logic                  errClear,
  input logic                  outValid,
  input logic [LANES*BITS-1:0] outData,
  input logic                  outOverrange,
  input logic                  outStart,
  input logic                  outStop,
  input logic [15:0]           outGp,
  input logic [15:0]           outHeader,
  input logic                  protoErr
);
  AST_START_STOP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(outStart && outStop)); // R6
  AST_STROBE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (outStart || outStop || outOverrange) |-> outValid); // R6
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid); // R2
  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid); // R2
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> $stable(outData)); // R2
  AST_GP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> $stable(outGp)); // R9
  AST_HEADER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !outStart |-> $stable(outHeader)); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (protoErr && !errClear) |=> protoErr); // R10
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    errClear |=> !protoErr); // R11
endmodule

bind recordFramer recordFramerChk #(.LANES(LANES), .BITS(BITS)) uChk (
  .clk          (clk),
  .rst_n        (rst_n),
  .inValid      (inValid),
  .errClear     (errClear),
  .outValid     (outValid),
  .outData      (outData),
  .outOverrange (outOverrange),
  .outStart     (outStart),
  .outStop      (outStop),
  .outGp        (outGp),
  .outHeader    (outHeader),
  .protoErr     (protoErr)
);

// File: tb/tb_recordFramer.sv
`timescale 1ns/1ps
module tb_recordFramer;
  localparam int LANES = 2;
  localparam int BITS  = 4;
  localparam int LEN_W = 4;
  localparam int DW    = LANES*BITS;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [LEN_W-1:0] recLen = 4'd3;
  logic             inValid = 1'b0;
  logic [DW-1:0]    inData = '0;
  logic [15:0]      inGp = '0;
  logic             inStart = 1'b0, inStop = 1'b0, errClear = 1'b0;
  logic             outValid, outOverrange, outStart, outStop, protoErr;
  logic [DW-1:0]    outData;
  logic [15:0]      outGp, outHeader;

  int checks = 0;
  int fails  = 0;
  int pos    = 0;
  int lenNow = 3;
  logic [DW-1:0] expData = '0;
  logic [15:0]   expGp = '0, expHdr = '0;
  logic          done = 1'b0;

  always #5 clk = ~clk;

  recordFramer #(.LANES(LANES), .BITS(BITS), .LEN_W(LEN_W)) dut (
    .clk(clk), .rst_n(rst_n), .recLen(recLen), .inValid(inValid),
    .inData(inData), .inGp(inGp), .inStart(inStart), .inStop(inStop),
    .errClear(errClear), .outValid(outValid), .outData(outData),
    .outOverrange(outOverrange), .outStart(outStart), .outStop(outStop),
    .outGp(outGp), .outHeader(outHeader), .protoErr(protoErr));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic isFs(input logic [BITS-1:0] v);
    return (v == 4'b1000) || (v == 4'b0111);
  endfunction

  // Drives one word, waits for the edge, checks the registered outputs.
  task automatic dataStep(input logic v, input logic [DW-1:0] d, input logic [15:0] gp);
    logic eStart, eStop, eOr;
    inValid = v; inData = d; inGp = gp;
    inStart = 1'b0; inStop = 1'b0; errClear = 1'b0;
    eStart = v && (pos == 0);
    eStop  = v && (pos == lenNow-1);
    eOr    = v && (isFs(d[3:0]) || isFs(d[7:4]));
    if (v) begin
      expData = d; expGp = gp;
      if (eStart) expHdr = gp;
      pos = (pos == lenNow-1) ? 0 : pos + 1;
    end
    @(posedge clk); #2;
    chk("R2 outValid", 32'(outValid), 32'(v));
    chk(v ? "R2 outData" : "R7 outData held", 32'(outData), 32'(expData));
    chk("R3 outOverrange", 32'(outOverrange), 32'(eOr));
    chk(v ? "R4 outStart" : "R7 outStart", 32'(outStart), 32'(eStart));
    chk(v ? "R4 outStop" : "R7 outStop", 32'(outStop), 32'(eStop));
    chk("R6 exclusive", 32'(outStart && outStop), 32'd0);
    chk("R9 outGp", 32'(outGp), 32'(expGp));
    chk("R8 outHeader", 32'(outHeader), 32'(expHdr));
  endtask

  task automatic protoStep(input logic v, input logic s, input logic p,
                           input logic clr, input logic expErr, input string req);
    inValid = v; inStart = s; inStop = p; errClear = clr;
    @(posedge clk); #2;
    chk(req, 32'(protoErr), 32'(expErr));
    if (v) pos = (pos == lenNow-1) ? 0 : pos + 1;
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R1 outValid", 32'(outValid), 32'd0);
    chk("R1 outStart", 32'(outStart), 32'd0);
    chk("R1 outOverrange", 32'(outOverrange), 32'd0);
    chk("R1 protoErr", 32'(protoErr), 32'd0);
    chk("R1 outHeader", 32'(outHeader), 32'd0);
    rst_n = 1'b1;
    @(posedge clk); #2;
    chk("R1 after release", 32'({outValid, outStart, outStop, outData, outGp}), 32'd0);

    // Exhaustive lane sweep with gaps, record length 3.
    for (int i = 0; i < 256; i++) begin
      dataStep(1'b1, 8'(i), 16'(i*37 + 3));
      if (i % 5 == 4) dataStep(1'b0, 8'(i ^ 8'h77), 16'hDEAD);
    end
    while (pos != 0) dataStep(1'b1, 8'h12, 16'h0101);

    // R5: clamped lengths.
    recLen = 4'd1; lenNow = 2;
    for (int i = 0; i < 8; i++) dataStep(1'b1, 8'(i * 17), 16'(i + 100));
    recLen = 4'd0;
    for (int i = 0; i < 6; i++) dataStep(1'b1, 8'(i * 9), 16'(i + 200));
    recLen = 4'd5; lenNow = 5;
    for (int i = 0; i < 12; i++) begin
      dataStep(1'b1, 8'(i * 29), 16'(i + 300));
      if (i % 3 == 1) dataStep(1'b0, 8'h80, 16'h5555);
    end

    // R10 / R11 incoming framing checks.
    protoStep(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R10 legal start");
    protoStep(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R10 start while open");
    protoStep(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R10 sticky");
    protoStep(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R11 clear");
    protoStep(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R10 legal stop");
    protoStep(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R10 stop while closed");
    protoStep(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R11 clear beats new error");
    protoStep(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R10 start with stop");
    protoStep(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R11 clear again");
    protoStep(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R7 invalid start ignored");
    protoStep(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R7 record stayed closed");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule